// File: doc/BRIEF.md
# CPU Idle Power State Controller

This block follows the processor's idle power level while the system is in its working state. It has three levels: C0 (running), C1 (halted, active idle) and C3 (deep idle, with the core asked to hold memory in self-refresh). There is no C2 level. Hardware events move the block between levels. A halt bus cycle takes it from C0 into C1. A software read of a dedicated entry register takes it into C3. An NMI, an unmasked interrupt or an SMI brings it back to C0. In C3, a bus-master request also brings it back to C0, but only when software has enabled that with a reload bit.

In C1, a bus-master request takes the processor out of idle for as long as the request lasts, so that the transfer can be served. When the request ends, the block goes back to C1 by itself, without a new halt cycle. In C0 the core runs at full speed or in throttled mode, as a throttle-enable control bit selects. A separate control bit gates the system arbiter; software sets it before entering C3 and clears it after waking. A sleep-state input holds the tracking in C0 and blocks any idle entry.

Software reaches the controls through a simple register port with single-cycle accesses. Reads are combinational and qualified by a read strobe.

Top module: `cpu_cstate_ctrl`

## Requirements
- R1: `cstate` uses the codes C0=2'b00, C1=2'b01 and C3=2'b11 and never shows 2'b10. A read of the status register at offset 0x10 returns the current code in bits [1:0] and zero in bits [7:2].
- R2: Bit 4 of the control register at offset 0x00 is the throttle enable, and it reads back. `throttle_on` is high only when the block is in C0 (and not serving a bus master from C1) with that bit set.
- R3: In C0, a `halt_cycle` with no wake event, no sleep and no entry read moves `cstate` to C1 on the next clock edge.
- R4: In C1, `nmi`, `intr` or `smi` moves `cstate` to C0 on the next clock edge.
- R5: In C1, `bm_req` makes `cstate` show C0 from the next edge on, for as long as `bm_req` stays high. On the edge after `bm_req` falls, `cstate` returns to C1 with no new halt cycle.
- R6: A read strobe at offset 0x05 while in C0 moves `cstate` to C3 on the next edge, and the read returns 0x00. A write to offset 0x05 has no effect on the state.
- R7: In C3, a wake event (`nmi`, `intr` or `smi`) moves `cstate` to C0 on the next edge. `bm_req` does the same only when the reload-enable bit (offset 0x0C, bit 1) is set; otherwise the block stays in C3.
- R8: `susp_refresh` is high exactly while `cstate` is C3. After leaving C3, `throttle_on` follows the throttle enable bit as it is at that moment.
- R9: Bit 0 of the register at offset 0x20 is the arbitration disable. It reads back and drives `arb_gate`.
- R10: Reserved bits read as zero and ignore writes. This covers the bits reserved for the absent C2 level at offset 0x0C, every bit other than 4 at 0x00, every bit other than 0 at 0x20, and every unmapped offset.
- R11: While `sleep_req` is high, `cstate` is forced to C0 on the next edge, and halt cycles and entry reads cause no idle entry.
- R12: When a wake event and an entry trigger (halt cycle or entry read) arrive in the same cycle, the wake event wins and `cstate` stays at C0.
- R13: Asserting `rst_n` low sets `cstate` to C0 and clears the throttle, reload and arbitration bits, and all outputs go low. Reset release reaches the logic after a synchronizer of `RST_STAGES` flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data, valid while the read strobe is high |
| halt_cycle | input | 1 | Halt bus cycle observed |
| nmi | input | 1 | Non-maskable interrupt |
| intr | input | 1 | Unmasked interrupt |
| smi | input | 1 | System management interrupt |
| bm_req | input | 1 | Bus-master request |
| sleep_req | input | 1 | System is leaving the working state |
| cstate | output | 2 | Current idle level code |
| throttle_on | output | 1 | Core runs in throttled C0 |
| susp_refresh | output | 1 | Suspend-refresh request to the core |
| arb_gate | output | 1 | Arbiter disable gate |

## Verification
The bench uses the default parameters: an 8-bit address and data path, the offsets 0x00, 0x05, 0x0C, 0x10 and 0x20, and a two-flop reset synchronizer. With these settings every control bit sits at a position the bench can set and clear through the register port. The directed sequences take the block through each level change, including the return from a C1 bus-master service, a C3 bus-master request with the reload bit both cleared and set, wake events that coincide with entry triggers, and sleep forcing. The two-cycle synchronizer keeps reset release short, so an asynchronous reset applied in the middle of a run can be checked within a few cycles.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

  localparam int CODE_W = 2;

  // externally visible level codes
  localparam logic [CODE_W-1:0] CODE_C0 = 2'b00;
  localparam logic [CODE_W-1:0] CODE_C1 = 2'b01;
  localparam logic [CODE_W-1:0] CODE_C3 = 2'b11;

  // internal sequencing states
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_HALTBM = 2'd2,
    ST_DEEP   = 2'd3
  } seq_state_t;

  function automatic logic [CODE_W-1:0] state_code(input seq_state_t s);
    case (s)
      ST_HALT: state_code = CODE_C1;
      ST_DEEP: state_code = CODE_C3;
      default: state_code = CODE_C0;
    endcase
  endfunction

endpackage

// File: rtl/cstate_rst_sync.sv
module cstate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES:0] chain;

  assign chain[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= 1'b0;
        else         stage_q <= chain[g];
      end
      assign chain[g+1] = stage_q;
    end
  endgenerate

  assign srst_n = chain[STAGES];

endmodule

// File: rtl/cstate_regs.sv
module cstate_regs #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int OFS_CTRL = 'h00,
  parameter int OFS_L3   = 'h05,
  parameter int OFS_BMC  = 'h0C,
  parameter int OFS_STAT = 'h10,
  parameter int OFS_ARB  = 'h20,
  parameter int THR_BIT  = 4,
  parameter int RLD_BIT  = 1,
  parameter int ARB_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [1:0]        code,
  output logic              thr_en,
  output logic              rld_en,
  output logic              arb_dis,
  output logic              deep_rd
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_L3   = ADDR_W'(OFS_L3);
  localparam logic [ADDR_W-1:0] A_BMC  = ADDR_W'(OFS_BMC);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ARB  = ADDR_W'(OFS_ARB);

  logic hit_ctrl, hit_bmc, hit_arb, hit_l3, hit_stat;
  logic thr_we, rld_we, arb_we;
  logic thr_d, rld_d, arb_d;
  logic thr_q, rld_q, arb_q;

  always_comb begin
    hit_ctrl = (addr == A_CTRL);
    hit_bmc  = (addr == A_BMC);
    hit_arb  = (addr == A_ARB);
    hit_l3   = (addr == A_L3);
    hit_stat = (addr == A_STAT);
    thr_we   = wr && hit_ctrl;
    rld_we   = wr && hit_bmc;
    arb_we   = wr && hit_arb;
    thr_d    = wdata[THR_BIT];
    rld_d    = wdata[RLD_BIT];
    arb_d    = wdata[ARB_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      rld_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      if (thr_we) thr_q <= thr_d;
      if (rld_we) rld_q <= rld_d;
      if (arb_we) arb_q <= arb_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_ctrl) rdata[THR_BIT] = thr_q;
      if (hit_bmc)  rdata[RLD_BIT] = rld_q;
      if (hit_arb)  rdata[ARB_BIT] = arb_q;
      if (hit_stat) rdata[1:0]     = code;
    end
  end

  assign thr_en  = thr_q;
  assign rld_en  = rld_q;
  assign arb_dis = arb_q;
  assign deep_rd = rd && hit_l3;

endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
  import cstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic       sleep,
  input  logic       halt,
  input  logic       deep_rd,
  input  logic       bm_req,
  input  logic       rld_en,
  output logic [1:0] code,
  output logic       bm_svc,
  output logic       in_deep
);

  seq_state_t st_q, st_d;
  logic leave;

  always_comb begin
    leave = wake || sleep;
    st_d  = st_q;
    case (st_q)
      ST_RUN: begin
        if (leave)        st_d = ST_RUN;
        else if (deep_rd) st_d = ST_DEEP;
        else if (halt)    st_d = ST_HALT;
      end
      ST_HALT: begin
        if (leave)        st_d = ST_RUN;
        else if (bm_req)  st_d = ST_HALTBM;
      end
      ST_HALTBM: begin
        if (leave)        st_d = ST_RUN;
        else if (!bm_req) st_d = ST_HALT;
      end
      ST_DEEP: begin
        if (leave)                 st_d = ST_RUN;
        else if (bm_req && rld_en) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign code    = state_code(st_q);
  assign bm_svc  = (st_q == ST_HALTBM);
  assign in_deep = (st_q == ST_DEEP);

endmodule

// File: rtl/cpu_cstate_ctrl.sv
module cpu_cstate_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int OFS_CTRL   = 'h00,
  parameter int OFS_L3     = 'h05,
  parameter int OFS_BMC    = 'h0C,
  parameter int OFS_STAT   = 'h10,
  parameter int OFS_ARB    = 'h20,
  parameter int THR_BIT    = 4,
  parameter int RLD_BIT    = 1,
  parameter int ARB_BIT    = 0,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              halt_cycle,
  input  logic              nmi,
  input  logic              intr,
  input  logic              smi,
  input  logic              bm_req,
  input  logic              sleep_req,
  output logic [1:0]        cstate,
  output logic              throttle_on,
  output logic              susp_refresh,
  output logic              arb_gate
);

  import cstate_pkg::*;

  logic srst_n;
  logic thr_en, rld_en, arb_dis, deep_rd;
  logic bm_svc, in_deep, wake;
  logic [1:0] code;

  cstate_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cstate_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_CTRL(OFS_CTRL), .OFS_L3(OFS_L3), .OFS_BMC(OFS_BMC),
    .OFS_STAT(OFS_STAT), .OFS_ARB(OFS_ARB),
    .THR_BIT(THR_BIT), .RLD_BIT(RLD_BIT), .ARB_BIT(ARB_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .addr    (reg_addr),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .rd      (reg_rd),
    .rdata   (reg_rdata),
    .code    (code),
    .thr_en  (thr_en),
    .rld_en  (rld_en),
    .arb_dis (arb_dis),
    .deep_rd (deep_rd)
  );

  assign wake = nmi || intr || smi;

  cstate_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .wake    (wake),
    .sleep   (sleep_req),
    .halt    (halt_cycle),
    .deep_rd (deep_rd),
    .bm_req  (bm_req),
    .rld_en  (rld_en),
    .code    (code),
    .bm_svc  (bm_svc),
    .in_deep (in_deep)
  );

  assign cstate       = code;
  assign throttle_on  = (code == CODE_C0) && !bm_svc && thr_en;
  assign susp_refresh = in_deep;
  assign arb_gate     = arb_dis;

endmodule

// File: rtl/cstate_chk.sv
module cstate_chk #(
  parameter int ADDR_W = 8,
  parameter int OFS_L3 = 'h05
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              halt_cycle,
  input logic              nmi,
  input logic              intr,
  input logic              smi,
  input logic              bm_req,
  input logic              sleep_req,
  input logic [1:0]        cstate,
  input logic              throttle_on,
  input logic              susp_refresh,
  input logic              rld_en,
  input logic              bm_svc
);

  logic wk, l3r;
  assign wk  = nmi || intr || smi;
  assign l3r = reg_rd && (reg_addr == ADDR_W'(OFS_L3));

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!srst_n)
    cstate != 2'b10);

  a_r2_throttle_only_c0: assert property (@(posedge clk) disable iff (!srst_n)
    throttle_on |-> (cstate == 2'b00));

  a_r3_halt_enters_c1: assert property (@(posedge clk) disable iff (!srst_n)
    (cstate == 2'b00 && !bm_svc && halt_cycle && !wk && !sleep_req && !l3r)
      |=> (cstate == 2'b01));

  a_r4_c1_wake: assert property (@(posedge clk) disable iff (!srst_n)
    (cstate == 2'b01 && wk) |=> (cstate == 2'b00));

  a_r6_read_enters_c3: assert property (@(posedge clk) disable iff (!srst_n)
    (cstate == 2'b00 && !bm_svc && l3r && !wk && !sleep_req) |=> (cstate == 2'b11));

  a_r7_c3_wake: assert property (@(posedge clk) disable iff (!srst_n)
    (cstate == 2'b11 && wk) |=> (cstate == 2'b00));

  a_r7_bm_needs_reload: assert property (@(posedge clk) disable iff (!srst_n)
    (cstate == 2'b11 && !rld_en && !wk && !sleep_req) |=> (cstate == 2'b11));

  a_r8_refresh_in_c3: assert property (@(posedge clk) disable iff (!srst_n)
    susp_refresh |-> (cstate == 2'b11));

  a_r11_sleep_forces_c0: assert property (@(posedge clk) disable iff (!srst_n)
    sleep_req |=> (cstate == 2'b00));

endmodule

bind cpu_cstate_ctrl cstate_chk #(.ADDR_W(ADDR_W), .OFS_L3(OFS_L3)) i_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .reg_addr     (reg_addr),
  .reg_rd       (reg_rd),
  .halt_cycle   (halt_cycle),
  .nmi          (nmi),
  .intr         (intr),
  .smi          (smi),
  .bm_req       (bm_req),
  .sleep_req    (sleep_req),
  .cstate       (cstate),
  .throttle_on  (throttle_on),
  .susp_refresh (susp_refresh),
  .rld_en       (rld_en),
  .bm_svc       (bm_svc)
);

// File: tb/test_cpu_cstate_ctrl.sv
module test_cpu_cstate_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_rd;
  logic [7:0] reg_rdata;
  logic       halt_cycle, nmi, intr, smi, bm_req, sleep_req;
  logic [1:0] cstate;
  logic       throttle_on, susp_refresh, arb_gate;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cpu_cstate_ctrl i_cpu_cstate_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .halt_cycle(halt_cycle), .nmi(nmi), .intr(intr), .smi(smi),
    .bm_req(bm_req), .sleep_req(sleep_req),
    .cstate(cstate), .throttle_on(throttle_on),
    .susp_refresh(susp_refresh), .arb_gate(arb_gate)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    reg_addr = 8'h00; reg_wr = 1'b0; reg_wdata = 8'h00; reg_rd = 1'b0;
    halt_cycle = 1'b0; nmi = 1'b0; intr = 1'b0; smi = 1'b0;
    bm_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    chk(reg_rdata, exp, req);
    reg_rd = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    #1;
    chk({6'd0, cstate}, 8'h00, "R13 state in reset");
    chk({5'd0, throttle_on, susp_refresh, arb_gate}, 8'h00, "R13 outputs in reset");
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic enter_c1();
    halt_cycle = 1'b1; tick(); halt_cycle = 1'b0;
  endtask

  task automatic enter_c3();
    reg_addr = 8'h05; reg_rd = 1'b1;
    #1;
    chk(reg_rdata, 8'h00, "R6 entry read data");
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk({6'd0, cstate}, 8'h00, "R13 C0 after reset");
    rd_check(8'h00, 8'h00, "R13 ctrl cleared");
    rd_check(8'h0C, 8'h00, "R13 reload cleared");
    rd_check(8'h20, 8'h00, "R13 arb cleared");
  endtask

  task automatic t_registers();
    wr_reg(8'h00, 8'hFF);
    rd_check(8'h00, 8'h10, "R2 throttle bit readback");
    chk({7'd0, throttle_on}, 8'h01, "R2 throttle_on in C0");
    wr_reg(8'h20, 8'hFF);
    rd_check(8'h20, 8'h01, "R9 arb readback");
    chk({7'd0, arb_gate}, 8'h01, "R9 arb_gate high");
    wr_reg(8'h20, 8'h00);
    chk({7'd0, arb_gate}, 8'h00, "R9 arb_gate low");
    wr_reg(8'h0C, 8'hFF);
    rd_check(8'h0C, 8'h02, "R10 C2 bits reserved");
    wr_reg(8'h0C, 8'h00);
    wr_reg(8'h33, 8'hFF);
    rd_check(8'h33, 8'h00, "R10 unmapped reads zero");
    rd_check(8'h10, 8'h00, "R1 status in C0");
    wr_reg(8'h05, 8'hFF);
    chk({6'd0, cstate}, 8'h00, "R6 write to entry reg ignored");
    wr_reg(8'h00, 8'h00);
    chk({7'd0, throttle_on}, 8'h00, "R2 throttle_on off");
  endtask

  task automatic t_c1();
    enter_c1();
    chk({6'd0, cstate}, 8'h01, "R3 halt enters C1");
    rd_check(8'h10, 8'h01, "R1 status C1");
    intr = 1'b1; tick(); intr = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R4 intr leaves C1");
    enter_c1();
    smi = 1'b1; tick(); smi = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R4 smi leaves C1");
    enter_c1();
    nmi = 1'b1; tick(); nmi = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R4 nmi leaves C1");
  endtask

  task automatic t_c1_bm();
    wr_reg(8'h00, 8'h10);
    enter_c1();
    bm_req = 1'b1; tick();
    chk({6'd0, cstate}, 8'h00, "R5 bus master shows C0");
    chk({7'd0, throttle_on}, 8'h00, "R2 no throttle during bm service");
    tick();
    chk({6'd0, cstate}, 8'h00, "R5 held while bm_req");
    bm_req = 1'b0; tick();
    chk({6'd0, cstate}, 8'h01, "R5 back to C1");
    nmi = 1'b1; tick(); nmi = 1'b0;
    wr_reg(8'h00, 8'h00);
  endtask

  task automatic t_c3();
    wr_reg(8'h20, 8'h01);
    enter_c3();
    chk({6'd0, cstate}, 8'h03, "R6 read enters C3");
    chk({7'd0, susp_refresh}, 8'h01, "R8 refresh in C3");
    rd_check(8'h10, 8'h03, "R1 status C3");
    bm_req = 1'b1; tick(); tick(); bm_req = 1'b0;
    chk({6'd0, cstate}, 8'h03, "R7 bm ignored without reload");
    wr_reg(8'h0C, 8'h02);
    wr_reg(8'h00, 8'h10);
    bm_req = 1'b1; tick(); bm_req = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R7 bm exits with reload");
    chk({7'd0, susp_refresh}, 8'h00, "R8 refresh off after exit");
    chk({7'd0, throttle_on}, 8'h01, "R8 resumes throttled");
    wr_reg(8'h20, 8'h00);
    wr_reg(8'h00, 8'h00);
    enter_c3();
    smi = 1'b1; tick(); smi = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R7 smi exits C3");
    chk({7'd0, throttle_on}, 8'h00, "R8 resumes full speed");
    wr_reg(8'h0C, 8'h00);
  endtask

  task automatic t_priority();
    halt_cycle = 1'b1; intr = 1'b1; tick();
    halt_cycle = 1'b0; intr = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R12 wake beats halt");
    reg_addr = 8'h05; reg_rd = 1'b1; nmi = 1'b1; tick();
    reg_rd = 1'b0; nmi = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R12 wake beats entry read");
  endtask

  task automatic t_sleep();
    enter_c1();
    sleep_req = 1'b1; tick();
    chk({6'd0, cstate}, 8'h00, "R11 sleep forces C0");
    halt_cycle = 1'b1; tick(); halt_cycle = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R11 halt blocked in sleep");
    reg_addr = 8'h05; reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    chk({6'd0, cstate}, 8'h00, "R11 entry read blocked in sleep");
    sleep_req = 1'b0; tick();
  endtask

  task automatic t_midrun_reset();
    wr_reg(8'h00, 8'h10);
    wr_reg(8'h20, 8'h01);
    enter_c3();
    do_reset();
    chk({6'd0, cstate}, 8'h00, "R13 reset leaves C3");
    chk({5'd0, throttle_on, susp_refresh, arb_gate}, 8'h00, "R13 outputs cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_registers();
    t_c1();
    t_c1_bm();
    t_c3();
    t_priority();
    t_sleep();
    t_midrun_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule